// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-driven SPI master that issues one serial-flash command each time software starts it. Software places the command byte in a dedicated register, programs how many payload bytes follow it and how many response bytes to collect, loads the payload through a single byte-wide data port into an eight-entry byte buffer, and then sets a start bit. The engine frames the transfer with chip select, shifts out the command byte, then the payload, then clocks in the response while holding the serial output low.

Response bytes land in the same buffer, in the entries that follow the payload. The buffer has one software pointer that every data-port access advances. Software clears that pointer through a control bit, skips over the bytes it sent and reads the response. The serial clock runs at a quarter of the system clock in mode 0, most significant bit first. The register bus is byte wide with a four-bit address. Reads return data in the same cycle, and any side effect of an access takes hold at the next clock edge.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, the control register (address 0x2) reads 0, the pointer (address 0xD) reads 0, the opcode and count registers read 0, spi_cs_n is 1, and spi_sck and spi_mosi are 0.
- R2: Address 0x0 holds the command byte and reads back what was written. The command byte is always the first byte shifted out of a frame and never occupies a buffer entry.
- R3: Address 0x1 holds the transmit count in bits [3:0] and the receive count in bits [7:4]. A field written above 8 is stored and read back as 8.
- R4: Address 0xC is the data port. A write stores the byte at the entry the pointer selects, and a read returns that entry; either access then advances the pointer by one, wrapping from 7 to 0. The pointer reads back in bits [2:0] of address 0xD, and bits [7:3] read 0.
- R5: Writing the control register with bit 4 set returns the pointer to 0 by the next cycle. Bit 4 always reads back 0.
- R6: Writing the control register with bit 0 set starts a frame. Bit 0 reads 1 from the next cycle until the frame ends, then clears on its own. A frame starts only through such a write.
- R7: During a frame, spi_cs_n stays low while the command byte, then buffer entries 0 up to count-1 in order, then the response bytes are shifted, with spi_mosi held at 0 for every response bit. While spi_cs_n is high, spi_sck and spi_mosi are 0.
- R8: The k-th response byte (from k=0) is stored in buffer entry (transmit count + k) modulo 8, and the software pointer is left unchanged by the frame.
- R9: SPI mode 0, most significant bit first. spi_sck idles low, and each bit takes 4 system clocks: 2 low, then 2 high. spi_mosi changes only while spi_sck is low, and spi_miso is sampled at the rising edge of spi_sck.
- R10: spi_cs_n is asserted for exactly 32·(1 + transmit count + receive count) + 4 system clocks, so it releases one serial-clock period after the last falling edge. Control bit 0 reads 0 once spi_cs_n has risen.
- R11: While a frame runs, writes to addresses 0x0, 0x1, 0x2 and 0xC have no effect, and data-port reads do not move the pointer.
- R12: With both counts zero, a frame carries only the 8 bits of the command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as bus_addr |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The assertions assume that a register access lasts exactly one cycle and that bus_wr and bus_rd are never high together. They also assume the address and write data are defined whenever a strobe is high, and that spi_miso changes only while spi_sck is low. The bench drives every access from one task per access type. Each task raises a single strobe for one cycle between falling clock edges and clears it before the next access. The behavioural flash model in the bench updates spi_miso only on a falling serial clock or when chip select falls. Frames are started with count pairs that cover an empty payload, a payload with no response, a buffer that fills exactly, and clamped counts whose response wraps back over entry 0. One frame also receives register writes and data-port reads while it runs.

// File: rtl/sce_pkg.sv
// Package sce_pkg: register addresses, control bit positions and the
// sequencer state type shared by the SPI command engine modules.
package sce_pkg;
    localparam logic [3:0] ADDR_OPCODE = 4'h0;
    localparam logic [3:0] ADDR_COUNTS = 4'h1;
    localparam logic [3:0] ADDR_CTRL   = 4'h2;
    localparam logic [3:0] ADDR_DATA   = 4'hC;
    localparam logic [3:0] ADDR_PTR    = 4'hD;
    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_PRST_BIT = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_XFER = 2'd1,
        SEQ_TAIL = 2'd2
    } seq_state_t;
endpackage

// File: rtl/sce_fifo.sv
// Module sce_fifo: byte buffer shared by software and the engine.
// Software reaches it through one pointer that advances on each access.
// The engine uses its own read and write indices.
// Assumes DEPTH is a power of two and that the software port is idle
// whenever the engine writes. The engine write wins in any clash.
module sce_fifo #(
    parameter int DEPTH = 8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_wr,
    input  logic          sw_rd,
    input  logic          ptr_clr,
    input  logic [7:0]    sw_wdata,
    output logic [7:0]    sw_rdata,
    output logic [IW-1:0] ptr,
    input  logic [IW-1:0] eng_ridx,
    output logic [7:0]    eng_rdata,
    input  logic          eng_we,
    input  logic [IW-1:0] eng_widx,
    input  logic [7:0]    eng_wdata
);
    logic [7:0] mem [DEPTH];

    // Software pointer: clear on request, otherwise step after each access.
    always_ff @(posedge clk) begin
        if (!rst_n)                ptr <= '0;
        else if (ptr_clr)          ptr <= '0;
        else if (sw_wr || sw_rd)   ptr <= (ptr == IW'(DEPTH - 1)) ? '0 : ptr + IW'(1);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // One storage byte, written by the engine or by the data port.
        always_ff @(posedge clk) begin
            if (!rst_n)                                mem[i] <= '0;
            else if (eng_we && eng_widx == IW'(i))     mem[i] <= eng_wdata;
            else if (sw_wr && ptr == IW'(i))           mem[i] <= sw_wdata;
        end
    end

    assign sw_rdata  = mem[ptr];
    assign eng_rdata = mem[eng_ridx];
endmodule

// File: rtl/sce_shifter.sv
// Module sce_shifter: mode-0 byte shifter, most significant bit first.
// A load pulse starts a byte. Each bit is DIV clocks: the low half, then
// the high half. The input is sampled as the clock rises. done pulses in
// the final clock of the byte, and a load in that same clock chains the
// next byte with no gap. Assumes DIV is even and at least 2.
module sce_shifter #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [PW-1:0] phase;
    logic [2:0]    bitn;
    logic [7:0]    tx_sr;
    logic [7:0]    rx_sr;
    logic          running;
    logic          sck_q;
    logic          last_phase;

    assign last_phase = (phase == PW'(DIV - 1));
    assign done       = running && last_phase && (bitn == 3'd7);
    assign sck        = sck_q;
    assign mosi       = running & tx_sr[7];
    assign rx_byte    = rx_sr;

    // Bit timing: phase counter, serial clock level, and both shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= '0;
            bitn    <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            running <= 1'b0;
            sck_q   <= 1'b0;
        end else if (load) begin
            tx_sr   <= tx_byte;
            phase   <= '0;
            bitn    <= '0;
            running <= 1'b1;
            sck_q   <= 1'b0;
        end else if (running) begin
            if (last_phase) begin
                phase <= '0;
                sck_q <= 1'b0;
                tx_sr <= {tx_sr[6:0], 1'b0};
                bitn  <= bitn + 3'd1;
                if (bitn == 3'd7) running <= 1'b0;
            end else begin
                phase <= phase + PW'(1);
                if (phase == PW'(HALF - 1)) begin
                    sck_q <= 1'b1;
                    rx_sr <= {rx_sr[6:0], miso};
                end
            end
        end
    end
endmodule

// File: rtl/sce_seq.sv
// Module sce_seq: byte sequencer for one command frame. Byte 0 is the
// command. Byte b (b >= 1) maps to buffer entry b-1: bytes up to tx_cnt
// are read from the buffer, and later bytes are received into it. After
// the last byte, chip select is held for one more serial-clock period.
// Assumes the counts and the command byte stay put while busy.
module sce_seq
    import sce_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DIV   = 4,
    parameter int IW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [7:0]    opcode,
    input  logic [CW-1:0] tx_cnt,
    input  logic [CW-1:0] rx_cnt,
    input  logic          sh_done,
    input  logic [7:0]    sh_rx,
    input  logic [7:0]    fifo_rdata,
    output logic          sh_load,
    output logic [7:0]    sh_byte,
    output logic [IW-1:0] ridx,
    output logic          we,
    output logic [IW-1:0] widx,
    output logic [7:0]    wdata,
    output logic          cs_n,
    output logic          busy
);
    localparam int BW = $clog2(2 * DEPTH + 2);
    localparam int TW = (DIV > 2) ? $clog2(DIV) : 1;

    seq_state_t    st;
    logic [BW-1:0] bidx;
    logic [BW-1:0] nidx;
    logic [BW-1:0] total;
    logic [TW-1:0] tail;
    logic          more;
    logic          cur_is_rx;
    logic          nxt_is_tx;

    assign total     = BW'(tx_cnt) + BW'(rx_cnt) + BW'(1);
    assign nidx      = bidx + BW'(1);
    assign more      = (nidx < total);
    assign cur_is_rx = (bidx > BW'(tx_cnt));
    assign nxt_is_tx = (nidx <= BW'(tx_cnt));
    assign ridx      = IW'(nidx - BW'(1));
    assign widx      = IW'(bidx - BW'(1));
    assign wdata     = sh_rx;
    assign cs_n      = (st == SEQ_IDLE);
    assign busy      = (st != SEQ_IDLE);

    // Load the next byte into the shifter and store each finished response byte.
    always_comb begin
        sh_load = 1'b0;
        sh_byte = '0;
        we      = 1'b0;
        case (st)
            SEQ_IDLE: if (go) begin
                sh_load = 1'b1;
                sh_byte = opcode;
            end
            SEQ_XFER: if (sh_done) begin
                we = cur_is_rx;
                if (more) begin
                    sh_load = 1'b1;
                    sh_byte = nxt_is_tx ? fifo_rdata : 8'h00;
                end
            end
            default: ;
        endcase
    end

    // Frame state, byte index and chip-select tail counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= SEQ_IDLE;
            bidx <= '0;
            tail <= '0;
        end else begin
            case (st)
                SEQ_IDLE: if (go) begin
                    st   <= SEQ_XFER;
                    bidx <= '0;
                end
                SEQ_XFER: if (sh_done) begin
                    if (more) bidx <= nidx;
                    else begin
                        st   <= SEQ_TAIL;
                        tail <= '0;
                    end
                end
                SEQ_TAIL: begin
                    if (tail == TW'(DIV - 1)) st <= SEQ_IDLE;
                    else                      tail <= tail + TW'(1);
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_cmd_engine.sv
// Module spi_cmd_engine: register-driven SPI flash command engine.
// Decodes the byte-wide register bus, holds the command and count
// registers, and connects the buffer, the sequencer and the shifter.
// Assumes one-cycle strobes and never both strobes in one cycle.
// While a frame runs, register writes and data-port steps are dropped.
module spi_cmd_engine
    import sce_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DIV   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       spi_cs_n
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    opcode_q;
    logic [CW-1:0] txc_q;
    logic [CW-1:0] rxc_q;
    logic          busy;
    logic          wr_ok;
    logic          go;
    logic          ptr_clr;
    logic          sw_wr;
    logic          sw_rd;
    logic [7:0]    sw_rdata;
    logic [IW-1:0] ptr;
    logic [IW-1:0] eng_ridx;
    logic [IW-1:0] eng_widx;
    logic [7:0]    eng_rdata;
    logic [7:0]    eng_wdata;
    logic          eng_we;
    logic          sh_load;
    logic          sh_done;
    logic [7:0]    sh_byte;
    logic [7:0]    sh_rx;

    function automatic logic [CW-1:0] clamp_cnt(input logic [3:0] f);
        return (32'(f) > DEPTH) ? CW'(DEPTH) : CW'(f);
    endfunction

    assign wr_ok   = bus_wr && !busy;
    assign go      = wr_ok && (bus_addr == ADDR_CTRL) && bus_wdata[CTRL_GO_BIT];
    assign ptr_clr = wr_ok && (bus_addr == ADDR_CTRL) && bus_wdata[CTRL_PRST_BIT];
    assign sw_wr   = wr_ok && (bus_addr == ADDR_DATA);
    assign sw_rd   = bus_rd && !busy && (bus_addr == ADDR_DATA);

    // Command byte and clamped count registers, held while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode_q <= '0;
            txc_q    <= '0;
            rxc_q    <= '0;
        end else if (wr_ok && bus_addr == ADDR_OPCODE) begin
            opcode_q <= bus_wdata;
        end else if (wr_ok && bus_addr == ADDR_COUNTS) begin
            txc_q <= clamp_cnt(bus_wdata[3:0]);
            rxc_q <= clamp_cnt(bus_wdata[7:4]);
        end
    end

    // Read multiplexer for the register bus.
    always_comb begin
        case (bus_addr)
            ADDR_OPCODE: bus_rdata = opcode_q;
            ADDR_COUNTS: bus_rdata = {4'(rxc_q), 4'(txc_q)};
            ADDR_CTRL:   bus_rdata = {7'd0, busy};
            ADDR_DATA:   bus_rdata = sw_rdata;
            ADDR_PTR:    bus_rdata = 8'(ptr);
            default:     bus_rdata = 8'h00;
        endcase
    end

    sce_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .sw_wr(sw_wr), .sw_rd(sw_rd), .ptr_clr(ptr_clr),
        .sw_wdata(bus_wdata), .sw_rdata(sw_rdata), .ptr(ptr),
        .eng_ridx(eng_ridx), .eng_rdata(eng_rdata),
        .eng_we(eng_we), .eng_widx(eng_widx), .eng_wdata(eng_wdata)
    );

    sce_seq #(.DEPTH(DEPTH), .DIV(DIV)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go),
        .opcode(opcode_q), .tx_cnt(txc_q), .rx_cnt(rxc_q),
        .sh_done(sh_done), .sh_rx(sh_rx), .fifo_rdata(eng_rdata),
        .sh_load(sh_load), .sh_byte(sh_byte), .ridx(eng_ridx),
        .we(eng_we), .widx(eng_widx), .wdata(eng_wdata),
        .cs_n(spi_cs_n), .busy(busy)
    );

    sce_shifter #(.DIV(DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .tx_byte(sh_byte),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
        .done(sh_done), .rx_byte(sh_rx)
    );
endmodule

// File: rtl/sce_checker.sv
// Module sce_checker: protocol and register properties of spi_cmd_engine.
// It is attached to every instance of the engine by the bind below.
module sce_checker
    import sce_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    bus_addr,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [7:0]    bus_wdata,
    input logic          sck,
    input logic          mosi,
    input logic          cs_n,
    input logic          busy,
    input logic [IW-1:0] ptr,
    input logic [7:0]    opcode_q,
    input logic [CW-1:0] txc_q,
    input logic [CW-1:0] rxc_q
);
    assert_sck_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    assert_mosi_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !mosi);

    assert_start_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(bus_wr && bus_addr == ADDR_CTRL && bus_wdata[CTRL_GO_BIT]));

    assert_cnt_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(txc_q) <= DEPTH) && (32'(rxc_q) <= DEPTH));

    assert_ptr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_wr && bus_addr == ADDR_CTRL && bus_wdata[CTRL_PRST_BIT]) |=> (ptr == '0));

    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_rd && bus_addr == ADDR_DATA) |=> (ptr == $past(ptr) + IW'(1)));

    assert_opcode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(opcode_q));

    assert_counts_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(txc_q) && $stable(rxc_q)));

    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr));
endmodule

bind spi_cmd_engine sce_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .sck(spi_sck), .mosi(spi_mosi),
    .cs_n(spi_cs_n), .busy(busy), .ptr(ptr), .opcode_q(opcode_q),
    .txc_q(txc_q), .rxc_q(rxc_q)
);

// File: tb/sim_spi_cmd_engine.sv
// Bench for spi_cmd_engine: a behavioural register model and a flash-side
// monitor check the serial lines on every clock and the registers on each access.
module sim_spi_cmd_engine;
    import sce_pkg::*;
    localparam int DEPTH = 8;
    localparam int DIV   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    wire  [7:0] bus_rdata;
    wire        spi_sck, spi_mosi, spi_cs_n;
    logic       spi_miso = 1'b0;

    spi_cmd_engine #(.DEPTH(DEPTH), .DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    int n_checks = 0;
    int n_errors = 0;

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model of the software-visible state.
    logic [7:0] m_fifo [DEPTH];
    int         m_ptr = 0;
    logic [7:0] m_op = '0;
    int         m_tx = 0, m_rx = 0;
    bit         m_busy = 1'b0;
    int         exp_bytes = 1;
    int         seed = 0;

    function automatic int clampc(input int f);
        return (f > DEPTH) ? DEPTH : f;
    endfunction

    function automatic logic [7:0] resp_byte(input int b);
        return 8'((b * 37) ^ 8'hC3 ^ seed);
    endfunction

    function automatic logic resp_bit(input int i);
        logic [7:0] r;
        r = resp_byte(i / 8);
        return r[7 - (i % 8)];
    endfunction

    // Flash-side model: captures spi_mosi on rising sck, presents response bits, checks frame shape.
    logic [7:0] cap [2*DEPTH+1];
    int   kk = 0, bitcnt = 0;
    logic prev_sck = 1'b0, prev_cs = 1'b1, prev_mosi = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!spi_cs_n) begin
                if (prev_cs) begin
                    kk = 0; bitcnt = 0;
                    spi_miso = resp_bit(0);
                end else kk++;
                check("R9", int'(spi_sck), ((kk % 4) >= 2 && kk < 32 * exp_bytes) ? 1 : 0, "sck waveform");
                if (!prev_cs && spi_mosi !== prev_mosi)
                    check("R9", int'(spi_sck), 0, "mosi moved while sck high");
                if (spi_sck && !prev_sck) begin
                    if (bitcnt / 8 <= 2 * DEPTH) cap[bitcnt/8] = {cap[bitcnt/8][6:0], spi_mosi};
                    bitcnt++;
                end
                if (!spi_sck && prev_sck) spi_miso = resp_bit(bitcnt);
            end else begin
                if (!prev_cs) begin
                    check("R10", kk, 32 * exp_bytes + 3, "last cycle index with cs low");
                    check("R7", bitcnt, 8 * exp_bytes, "bits in frame");
                end
                check("R7", int'({spi_sck, spi_mosi}), 0, "idle serial lines");
            end
            prev_sck  = spi_sck;
            prev_cs   = spi_cs_n;
            prev_mosi = spi_mosi;
        end
    end

    // One-cycle register write; the model follows unless a frame runs.
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (!m_busy) begin
            case (a)
                ADDR_OPCODE: m_op = d;
                ADDR_COUNTS: begin m_tx = clampc(int'(d[3:0])); m_rx = clampc(int'(d[7:4])); end
                ADDR_CTRL: begin
                    if (d[4]) m_ptr = 0;
                    if (d[0]) begin m_busy = 1'b1; exp_bytes = 1 + m_tx + m_rx; end
                end
                ADDR_DATA: begin m_fifo[m_ptr] = d; m_ptr = (m_ptr + 1) % DEPTH; end
                default: ;
            endcase
        end
    endtask

    // One-cycle register read, sampled before the committing edge.
    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        if (!m_busy && a == ADDR_DATA) m_ptr = (m_ptr + 1) % DEPTH;
    endtask

    // Runs one command frame and checks bytes sent, bytes stored and the pointer.
    task automatic run_cmd(input logic [7:0] op, input logic [7:0] cnts, input int pseed, input bit meddle);
        logic [7:0] snap [DEPTH];
        logic [7:0] d;
        int polls;
        wr(ADDR_OPCODE, op);
        wr(ADDR_COUNTS, cnts);
        wr(ADDR_CTRL, 8'h10);
        for (int i = 0; i < m_tx; i++) wr(ADDR_DATA, 8'(pseed + i * 29));
        wr(ADDR_CTRL, 8'h10);
        for (int i = 0; i < DEPTH; i++) snap[i] = m_fifo[i];
        seed = pseed;
        wr(ADDR_CTRL, 8'h01);
        rd(ADDR_CTRL, d);
        check("R6", int'(d), 1, "control reads busy after start");
        if (meddle) begin
            // R11: all of these must be dropped while the frame runs.
            wr(ADDR_OPCODE, 8'h77);
            wr(ADDR_COUNTS, 8'h11);
            wr(ADDR_DATA, 8'hEE);
            wr(ADDR_CTRL, 8'h11);
            rd(ADDR_DATA, d);
            rd(ADDR_PTR, d);
            check("R11", int'(d), m_ptr, "pointer during frame");
        end
        polls = 0;
        d = 8'h01;
        while (d[0] && polls < 2000) begin rd(ADDR_CTRL, d); polls++; end
        check("R6", int'(d), 0, "start bit self-clears");
        check("R10", int'(spi_cs_n), 1, "cs released when start bit clears");
        m_busy = 1'b0;
        check("R2", int'(cap[0]), int'(m_op), "first byte is command");
        for (int i = 0; i < m_tx; i++)
            check("R7", int'(cap[1+i]), int'(snap[i]), "payload byte");
        for (int j = 0; j < m_rx; j++)
            check("R7", int'(cap[1+m_tx+j]), 0, "mosi low during response");
        for (int j = 0; j < m_rx; j++)
            m_fifo[(m_tx + j) % DEPTH] = resp_byte(1 + m_tx + j);
        rd(ADDR_PTR, d);
        check("R8", int'(d), m_ptr, "pointer untouched by frame");
        wr(ADDR_CTRL, 8'h10);
        for (int i = 0; i < DEPTH; i++) begin
            rd(ADDR_DATA, d);
            check("R8", int'(d), int'(m_fifo[i]), "buffer entry after frame");
        end
        rd(ADDR_PTR, d);
        check("R4", int'(d), 0, "pointer wrapped after full sweep");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < DEPTH; i++) m_fifo[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", int'({spi_cs_n, spi_sck, spi_mosi}), 3'b100, "serial lines after reset");
        rd(ADDR_CTRL, d);   check("R1", int'(d), 0, "control after reset");
        rd(ADDR_PTR, d);    check("R1", int'(d), 0, "pointer after reset");
        rd(ADDR_OPCODE, d); check("R1", int'(d), 0, "opcode after reset");
        rd(ADDR_COUNTS, d); check("R1", int'(d), 0, "counts after reset");
        // R2 opcode register
        wr(ADDR_OPCODE, 8'h5C); rd(ADDR_OPCODE, d); check("R2", int'(d), 8'h5C, "opcode readback");
        // R4 data port and pointer
        wr(ADDR_DATA, 8'h11); wr(ADDR_DATA, 8'h22); wr(ADDR_DATA, 8'h33);
        rd(ADDR_PTR, d); check("R4", int'(d), 3, "pointer after three writes");
        wr(ADDR_CTRL, 8'h10);
        rd(ADDR_PTR, d); check("R5", int'(d), 0, "pointer cleared");
        rd(ADDR_CTRL, d); check("R5", int'(d), 0, "bit 4 reads zero");
        for (int i = 0; i < 3; i++) begin
            rd(ADDR_DATA, d); check("R4", int'(d), int'(m_fifo[i]), "data port read");
        end
        for (int i = 0; i < 5; i++) wr(ADDR_DATA, 8'(8'hA0 + i));
        rd(ADDR_PTR, d); check("R4", int'(d), 0, "pointer wraps 7 to 0");
        // R3 count clamping
        wr(ADDR_COUNTS, 8'h9A); rd(ADDR_COUNTS, d); check("R3", int'(d), 8'h88, "counts clamp to 8");
        wr(ADDR_COUNTS, 8'h35); rd(ADDR_COUNTS, d); check("R3", int'(d), 8'h35, "counts in range");
        // Frames
        run_cmd(8'h9F, 8'h30, 17, 1'b0);
        run_cmd(8'h02, 8'h04, 90, 1'b0);
        run_cmd(8'h0B, 8'h44, 45, 1'b0);
        run_cmd(8'h06, 8'h00, 3, 1'b0);
        check("R12", int'(cap[0]), 8'h06, "command-only frame");
        run_cmd(8'hAB, 8'hFF, 201, 1'b0);
        run_cmd(8'h05, 8'h21, 66, 1'b1);
        rd(ADDR_OPCODE, d); check("R11", int'(d), 8'h05, "opcode write during frame dropped");
        rd(ADDR_COUNTS, d); check("R11", int'(d), 8'h21, "count write during frame dropped");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule